// File: doc/BRIEF.md
# Interrupt Flag Status Aggregator

This block gathers the interrupt events of one group of up to sixteen sources into a single register set. Each event names a global source number. The block owns one group, chosen at build time. It keeps an event only when the number's group index (the number divided by the group width) equals its own. The remainder of that division picks the bit in a status register, and the bit stays set until software clears it. An enable register masks the status bits. A read-only pending register gives their bitwise AND. A one-cycle-late OR of the pending bits drives a request line to a downstream interrupt level controller.

Software must read a flag as one before it can clear it. A status read records, for each bit, that software has seen that bit set. A later write of zero to a recorded bit clears it and uses up the record. A zero written to any other bit does nothing. So does a one written to any bit. To clear a single flag, software writes all ones except a zero at that position. Bit positions marked as unused in a build-time mask never set and always read as zero.

The register interface is single-ported and 16 bits wide. Read data is registered and appears one cycle after the read request.

Top module: `irq_flag_agg`

## Requirements
- R1: An event with `evt_valid` high sets status bit `evt_num % 16` at the next clock edge, provided `evt_num / 16` equals `GROUP_IDX`. Events with any other group index change no bit.
- R2: Writing a one to a status bit never changes that bit.
- R3: Writing zero to a status bit clears it only if a status read has returned one for that bit since it was last cleared. Otherwise the bit stays set.
- R4: When an event for a bit arrives in the same cycle as a valid clear of that bit, the bit stays set. The clear still uses up the read record, so a further zero-write with no read in between leaves the bit set.
- R5: The pending register (address 2) reads as status AND enable. Writes to address 2 have no effect.
- R6: The enable register (address 1) is read/write over all 16 bits. A status bit still sets while its enable bit is zero.
- R7: Status bits whose position is zero in `IMPL_MASK` never set, and they read as zero in both status and pending.
- R8: `irq` is high in a cycle exactly when the OR of the pending bits was high in the previous cycle.
- R9: Register map: address 0 is status, address 1 is enable, address 2 is pending, and address 3 reads as zero. `rdata` shows the register addressed by a read (`req_valid` high, `req_write` low) one cycle after the request, and holds its value otherwise. After reset, status and enable are zero, and `irq` and `rdata` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| evt_valid | input | 1 | An event is presented this cycle |
| evt_num | input | NUM_W | Global source number of the event |
| req_valid | input | 1 | Register access this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 2 | Register address |
| req_wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data |
| irq | output | 1 | Registered request to the interrupt level controller |

## Verification
A wrong status or enable bit shows on `irq` one cycle after it goes wrong, whenever the two registers overlap. It also shows in the data of the next status or pending read. A lost or false read record stays hidden until the next zero-write to that bit. The bench therefore follows every clear attempt with a status read, and the wrong value appears two cycles after the write. The bench also runs simultaneous event-and-clear cycles and back-to-back zero-writes, so that a read record that is not used up shows in the next read.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int REG_W  = 16;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    SEL_STATUS = 2'd0,
    SEL_ENABLE = 2'd1,
    SEL_PEND   = 2'd2,
    SEL_NONE   = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/irq_src_decode.sv
module irq_src_decode #(
  parameter int          W         = 16,
  parameter int          NUM_W     = 8,
  parameter int          GROUP_IDX = 1,
  parameter logic [W-1:0] IMPL_MASK = '1
) (
  input  logic             evt_valid,
  input  logic [NUM_W-1:0] evt_num,
  output logic [W-1:0]     set_vec
);
  localparam int POS_W = $clog2(W);

  logic [NUM_W-1:0] grp;
  logic [POS_W-1:0] pos;
  logic             grp_hit;

  assign grp     = evt_num >> POS_W;
  assign pos     = evt_num[POS_W-1:0];
  assign grp_hit = evt_valid && (grp == NUM_W'(GROUP_IDX));

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (IMPL_MASK[i]) begin : g_impl
      assign set_vec[i] = grp_hit && (pos == POS_W'(i));
    end else begin : g_tied
      assign set_vec[i] = 1'b0;
    end
  end
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int           W         = 16,
  parameter logic [W-1:0] IMPL_MASK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_vec,
  input  logic         rd_stat,
  input  logic         wr_stat,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] status_q,
  output logic [W-1:0] armed_q
);
  logic [W-1:0] clr_vec;
  logic [W-1:0] status_n;
  logic [W-1:0] armed_n;
  logic         upd_en;

  always_comb begin
    clr_vec  = wr_stat ? (armed_q & ~wdata) : '0;
    status_n = ((status_q & ~clr_vec) | set_vec) & IMPL_MASK;
    armed_n  = ((armed_q & ~clr_vec) | (rd_stat ? status_q : '0)) & IMPL_MASK;
    upd_en   = rd_stat | wr_stat | (|set_vec);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      armed_q  <= '0;
    end else if (upd_en) begin
      status_q <= status_n;
      armed_q  <= armed_n;
    end
  end
endmodule

// File: rtl/irq_flag_agg.sv
module irq_flag_agg
  import irq_agg_pkg::*;
#(
  parameter int               NUM_W     = 8,
  parameter int               GROUP_IDX = 1,
  parameter logic [REG_W-1:0] IMPL_MASK = 16'h7FFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_valid,
  input  logic [NUM_W-1:0]  evt_num,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [REG_W-1:0]  req_wdata,
  output logic [REG_W-1:0]  rdata,
  output logic              irq
);
  logic [1:0]       rst_sync_q;
  logic             rst_n_s;
  logic [REG_W-1:0] set_vec;
  logic [REG_W-1:0] status_q;
  logic [REG_W-1:0] armed_q;
  logic [REG_W-1:0] enable_q;
  logic [REG_W-1:0] pend;
  logic [REG_W-1:0] rd_mux;
  logic [REG_W-1:0] rdata_q;
  logic             irq_q;
  logic             rd_op;
  logic             wr_op;
  logic             rd_stat;
  logic             wr_stat;
  logic             wr_en;
  reg_sel_e         sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  irq_src_decode #(
    .W(REG_W), .NUM_W(NUM_W), .GROUP_IDX(GROUP_IDX), .IMPL_MASK(IMPL_MASK)
  ) u_dec (
    .evt_valid(evt_valid), .evt_num(evt_num), .set_vec(set_vec)
  );

  always_comb begin
    sel     = reg_sel_e'(req_addr);
    rd_op   = req_valid && !req_write;
    wr_op   = req_valid && req_write;
    rd_stat = rd_op && (sel == SEL_STATUS);
    wr_stat = wr_op && (sel == SEL_STATUS);
    wr_en   = wr_op && (sel == SEL_ENABLE);
    pend    = status_q & enable_q;
    case (sel)
      SEL_STATUS: rd_mux = status_q;
      SEL_ENABLE: rd_mux = enable_q;
      SEL_PEND:   rd_mux = pend;
      default:    rd_mux = '0;
    endcase
  end

  irq_flag_bank #(
    .W(REG_W), .IMPL_MASK(IMPL_MASK)
  ) u_bank (
    .clk(clk), .rst_n(rst_n_s), .set_vec(set_vec),
    .rd_stat(rd_stat), .wr_stat(wr_stat), .wdata(req_wdata),
    .status_q(status_q), .armed_q(armed_q)
  );

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) enable_q <= '0;
    else if (wr_en) enable_q <= req_wdata;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) rdata_q <= '0;
    else if (rd_op) rdata_q <= rd_mux;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) irq_q <= 1'b0;
    else          irq_q <= |pend;
  end

  assign rdata = rdata_q;
  assign irq   = irq_q;
endmodule

// File: rtl/irq_flag_agg_chk.sv
module irq_flag_agg_chk #(
  parameter int           W         = 16,
  parameter logic [W-1:0] IMPL_MASK = '1
) (
  input logic         clk,
  input logic         rst_n_s,
  input logic [W-1:0] set_vec,
  input logic [W-1:0] status_q,
  input logic [W-1:0] armed_q,
  input logic [W-1:0] enable_q,
  input logic         irq
);
  AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n_s)
    (set_vec != '0) |=> ((status_q & $past(set_vec)) == $past(set_vec))); // R1

  AST_UNARMED_STAYS: assert property (@(posedge clk) disable iff (!rst_n_s)
    1'b1 |=> (($past(status_q & ~armed_q) & ~status_q) == '0)); // R3

  AST_UNIMPL_ZERO: assert property (@(posedge clk) disable iff (!rst_n_s)
    ((status_q & ~IMPL_MASK) == '0)); // R7

  AST_IRQ_LAGS: assert property (@(posedge clk) disable iff (!rst_n_s)
    1'b1 |=> (irq == |($past(status_q & enable_q)))); // R8

  AST_ARMED_ONLY_SET: assert property (@(posedge clk) disable iff (!rst_n_s)
    ((armed_q & ~status_q) == '0)); // R3
endmodule

bind irq_flag_agg irq_flag_agg_chk #(.W(16), .IMPL_MASK(IMPL_MASK)) u_chk (
  .clk(clk), .rst_n_s(rst_n_s), .set_vec(set_vec), .status_q(status_q),
  .armed_q(armed_q), .enable_q(enable_q), .irq(irq)
);

// File: tb/irq_flag_agg_test.sv
`timescale 1ns/1ps
module irq_flag_agg_test;
  localparam int          GRP  = 1;
  localparam logic [15:0] MASK = 16'h7FFF;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        evt_valid;
  logic [7:0]  evt_num;
  logic        req_valid;
  logic        req_write;
  logic [1:0]  req_addr;
  logic [15:0] req_wdata;
  logic [15:0] rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;

  logic [15:0] m_status, m_armed, m_enable;

  always #10 clk = ~clk;

  irq_flag_agg #(.NUM_W(8), .GROUP_IDX(GRP), .IMPL_MASK(MASK)) uut (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_num(evt_num),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .rdata(rdata), .irq(irq)
  );

  function automatic logic [15:0] f_set(input logic v, input logic [7:0] n);
    logic [15:0] r = '0;
    if (v && (n / 16 == GRP) && MASK[n % 16]) r[n % 16] = 1'b1;
    return r;
  endfunction

  function automatic logic [15:0] f_read(input logic [1:0] a);
    case (a)
      2'd0:    return m_status;
      2'd1:    return m_enable;
      2'd2:    return m_status & m_enable;
      default: return 16'h0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic w, input logic [1:0] a,
                      input logic [15:0] d, input logic ev, input logic [7:0] n,
                      input string tag);
    logic [15:0] sv, clr, exp_rd, n_st, n_ar, n_en;
    logic        exp_irq;
    evt_valid = ev; evt_num = n;
    req_valid = v; req_write = w; req_addr = a; req_wdata = d;
    sv      = f_set(ev, n);
    exp_rd  = f_read(a);
    exp_irq = |(m_status & m_enable);
    clr     = (v && w && a == 2'd0) ? (m_armed & ~d) : 16'h0;
    n_st    = ((m_status & ~clr) | sv) & MASK;
    n_ar    = ((m_armed & ~clr) | ((v && !w && a == 2'd0) ? m_status : 16'h0)) & MASK;
    n_en    = (v && w && a == 2'd1) ? d : m_enable;
    @(posedge clk);
    @(negedge clk);
    m_status = n_st; m_armed = n_ar; m_enable = n_en;
    check("R8 irq", {15'h0, irq}, {15'h0, exp_irq});
    if (v && !w) check(tag, rdata, exp_rd);
  endtask

  task automatic rd(input logic [1:0] a, input string tag);
    step(1'b1, 1'b0, a, 16'h0, 1'b0, 8'h0, tag);
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    step(1'b1, 1'b1, a, d, 1'b0, 8'h0, "wr");
  endtask

  task automatic ev(input logic [7:0] n);
    step(1'b0, 1'b0, 2'd0, 16'h0, 1'b1, n, "ev");
  endtask

  initial begin
    #3_000_000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'h1234_5678);
    m_status = '0; m_armed = '0; m_enable = '0;
    evt_valid = 0; evt_num = 0; req_valid = 0; req_write = 0;
    req_addr = 0; req_wdata = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R9 reset irq", {15'h0, irq}, 16'h0);
    check("R9 reset rdata", rdata, 16'h0);
    rd(2'd0, "R9 reset status");
    rd(2'd1, "R9 reset enable");
    // R1: in-group event, then out-of-group event
    ev(8'd19);
    ev(8'd3);
    ev(8'd35);
    // R3: unarmed zero-write leaves bit set
    wr(2'd0, 16'hFFF7);
    rd(2'd0, "R1 R3 unarmed clear");
    wr(2'd0, 16'hFFFF);
    rd(2'd0, "R2 write ones");
    wr(2'd0, 16'hFFF7);
    rd(2'd0, "R3 armed clear");
    // R4: clear collides with new event, record consumed
    ev(8'd21);
    rd(2'd0, "R4 arm");
    step(1'b1, 1'b1, 2'd0, 16'hFFDF, 1'b1, 8'd21, "wr");
    wr(2'd0, 16'hFFDF);
    rd(2'd0, "R4 event wins and record consumed");
    wr(2'd0, 16'hFFDF);
    rd(2'd0, "R4 clear after rearm");
    // R6 / R5 / R8
    ev(8'd16);
    rd(2'd0, "R6 status sets while disabled");
    rd(2'd2, "R5 pending masked");
    wr(2'd1, 16'h0001);
    rd(2'd1, "R6 enable readback");
    rd(2'd2, "R5 pending");
    wr(2'd2, 16'h0000);
    rd(2'd2, "R5 pending write ignored");
    // R7: unimplemented position
    ev(8'd31);
    wr(2'd1, 16'hFFFF);
    rd(2'd0, "R7 status unimpl");
    rd(2'd2, "R7 pending unimpl");
    rd(2'd3, "R9 addr3 zero");
    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic [1:0]  a;
      logic [15:0] d;
      logic [7:0]  n;
      logic        v, w, e;
      a = 2'($urandom_range(0, 3));
      v = ($urandom_range(0, 3) != 0);
      w = ($urandom_range(0, 2) == 0);
      d = 16'($urandom) | 16'($urandom);
      e = ($urandom_range(0, 1) == 1);
      n = ($urandom_range(0, 4) == 0) ? 8'($urandom) : 8'(16 + $urandom_range(0, 15));
      step(v, w, a, d, e, n,
           (a == 2'd0) ? "R3 rnd status" : (a == 2'd1) ? "R6 rnd enable" :
           (a == 2'd2) ? "R5 rnd pending" : "R9 rnd addr3");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule